// File: doc/BRIEF.md
# Independent Watchdog Timer

This block is a watchdog timer that runs from a slow clock separate from the bus clock. Software writes command codes and configuration values through a small write-only port in the bus domain. A 12-bit down-counter runs in the slow domain, stepped by a programmable power-of-two divider. If software fails to refresh it in time, the block raises a one-cycle system reset request. Once started, the timer cannot be stopped, and the slow oscillator must stay enabled. Only the block reset `rst_n` returns it to idle.

Software must unlock configuration writes with a key code before changing the divider, the reload value or the window. Each accepted value crosses into the slow domain through a toggle handshake with two-flop synchronizers. A per-field busy flag stays set until the slow domain acknowledges the value. A window value makes a refresh that comes too early raise the same reset request as an expiry.

Top module: `indep_watchdog`

## Requirements
- R1: After reset: `running`=0, `osc_force_on`=0, `busy`=0, `rst_req`=0 and `count`=0xFFF. The defaults are divider select 0, reload value 0xFFF and window 0xFFF.
- R2: Writing key 0xCCCC (`wr_sel`=0, `wr_data[15:0]`) starts the timer. `running` and `osc_force_on` go high on the next bus clock.
- R3: While running, consecutive expiry pulses are exactly D*(RLR+1) slow cycles apart. D = 4<<min(PR,6), PR comes from `wr_data[2:0]` with `wr_sel`=1, and RLR comes from `wr_data[11:0]` with `wr_sel`=2.
- R4: `rst_req` is high for exactly one slow cycle at a time.
- R5: Writes to the divider, reload and window fields are ignored unless key 0x5555 was the last key written. An ignored write leaves the busy flags at 0 and leaves the timing unchanged.
- R6: Writing any key other than 0x5555 re-locks configuration writes. This includes 0xAAAA and 0xCCCC.
- R7: An accepted write sets its busy bit on the next bus clock. Bit 0 is the divider, bit 1 the reload value and bit 2 the window. The bit clears after the slow domain acknowledges the write. A write to a field whose busy bit is set is ignored.
- R8: Key 0xAAAA written while running reloads the counter with RLR and restarts the divider phase. Regular refreshes prevent any expiry.
- R9: A refresh that arrives while `count` is above the window value (`wr_sel`=3, `wr_data[11:0]`) raises `rst_req`. A window of 0xFFF never does.
- R10: No key value stops the timer. `running` stays high and expiries continue until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| slow_clk | input | 1 | Slow oscillator clock for the counter |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write strobe, one bus cycle |
| wr_sel | input | 2 | Target: 0 key, 1 divider select, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| running | output | 1 | Timer started (bus domain) |
| osc_force_on | output | 1 | Slow oscillator enable forced on |
| busy | output | 3 | Update pending: divider, reload, window |
| count | output | 12 | Current counter value (slow domain) |
| rst_req | output | 1 | One-cycle system reset request (slow domain) |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a 3-bit divider select, and a divider capped at shift 6. It keeps reload values small, so that many full expiry periods fit in a short run. Random divider selects include 7, which exercises the cap at 256. Window tests use a reload of 200 and a divider of 16. This leaves enough counts above and below the window to place refreshes on either side without ambiguity.

// File: rtl/indep_watchdog.sv
module indep_watchdog #(
  parameter int CW    = 12,
  parameter int PW    = 3,
  parameter int MAXSH = 6
) (
  input  logic          bus_clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [15:0]   wr_data,
  output logic          running,
  output logic          osc_force_on,
  output logic [2:0]    busy,
  output logic [CW-1:0] count,
  output logic          rst_req
);
  localparam int DW = MAXSH + 3;
  localparam logic [15:0] K_START = 16'hCCCC;
  localparam logic [15:0] K_FEED  = 16'hAAAA;
  localparam logic [15:0] K_OPEN  = 16'h5555;
  localparam logic [PW-1:0] SH_CAP = PW'(MAXSH);

  // bus domain
  logic          unlock_q, run_q, start_t, feed_t;
  logic [PW-1:0] pr_b;
  logic [CW-1:0] rlr_b, win_b;
  logic [2:0]    req_t, ack_m, ack_s, rq_d;
  logic [2:0]    cfg_wr;

  wire key_wr = wr_en && (wr_sel == 2'd0);
  assign cfg_wr[0] = wr_en && wr_sel == 2'd1 && unlock_q && !busy[0];
  assign cfg_wr[1] = wr_en && wr_sel == 2'd2 && unlock_q && !busy[1];
  assign cfg_wr[2] = wr_en && wr_sel == 2'd3 && unlock_q && !busy[2];
  assign busy = req_t ^ ack_s;
  assign running = run_q;
  assign osc_force_on = run_q;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      run_q    <= 1'b0;
      start_t  <= 1'b0;
      feed_t   <= 1'b0;
      pr_b     <= '0;
      rlr_b    <= '1;
      win_b    <= '1;
      req_t    <= '0;
      ack_m    <= '0;
      ack_s    <= '0;
    end else begin
      if (key_wr) begin
        unlock_q <= (wr_data == K_OPEN);
        if (wr_data == K_START && !run_q) begin
          run_q   <= 1'b1;
          start_t <= ~start_t;
        end
        if (wr_data == K_FEED && run_q) feed_t <= ~feed_t;
      end
      if (cfg_wr[0]) pr_b  <= wr_data[PW-1:0];
      if (cfg_wr[1]) rlr_b <= wr_data[CW-1:0];
      if (cfg_wr[2]) win_b <= wr_data[CW-1:0];
      req_t <= req_t ^ cfg_wr;
      ack_m <= rq_d;
      ack_s <= ack_m;
    end
  end

  // slow domain
  logic [2:0]    rq_m, rq_s;
  logic          st_m, st_s, st_d, fd_m, fd_s, fd_d;
  logic          run_s, rst_q;
  logic [PW-1:0] pr_a;
  logic [CW-1:0] rlr_a, win_a, cnt_q;
  logic [DW-1:0] div_q;

  wire [PW-1:0] sh      = (pr_a > SH_CAP) ? SH_CAP : pr_a;
  wire [DW-1:0] div_lim = (DW'(4) << sh) - DW'(1);
  wire          tick    = div_q >= div_lim;
  wire          start   = st_s ^ st_d;
  wire          feed    = fd_s ^ fd_d;
  wire [2:0]    upd     = rq_s ^ rq_d;

  assign count   = cnt_q;
  assign rst_req = rst_q;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_m <= '0; rq_s <= '0; rq_d <= '0;
      st_m <= 1'b0; st_s <= 1'b0; st_d <= 1'b0;
      fd_m <= 1'b0; fd_s <= 1'b0; fd_d <= 1'b0;
      run_s <= 1'b0;
      rst_q <= 1'b0;
      pr_a  <= '0;
      rlr_a <= '1;
      win_a <= '1;
      cnt_q <= '1;
      div_q <= '0;
    end else begin
      rq_m <= req_t;   rq_s <= rq_m;   rq_d <= rq_s;
      st_m <= start_t; st_s <= st_m;   st_d <= st_s;
      fd_m <= feed_t;  fd_s <= fd_m;   fd_d <= fd_s;
      if (upd[0]) pr_a  <= pr_b;
      if (upd[1]) rlr_a <= rlr_b;
      if (upd[2]) win_a <= win_b;
      rst_q <= 1'b0;
      if (start) begin
        run_s <= 1'b1;
        cnt_q <= rlr_a;
        div_q <= '0;
      end else if (run_s) begin
        if (feed) begin
          cnt_q <= rlr_a;
          div_q <= '0;
          rst_q <= (cnt_q > win_a) && !rst_q;
        end else if (tick) begin
          div_q <= '0;
          if (cnt_q == '0) begin
            rst_q <= !rst_q;
            cnt_q <= rlr_a;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  // R4
  rst_pulse_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  // R2
  rst_needs_run_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    rst_q |-> run_s);
  // R10
  no_stop_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    run_q |=> run_q);

  for (genvar k = 0; k < 3; k++) begin : g_busy_chk
    // R5 R7
    busy_cause_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(busy[k]) |-> $past(wr_en && unlock_q));
  end
endmodule

// File: tb/sim_indep_watchdog.sv
module sim_indep_watchdog;
  logic bus_clk = 0, slow_clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic running, osc_force_on, rst_req;
  logic [2:0] busy;
  logic [11:0] count;

  int errors = 0, checks = 0;
  int sc = 0, pc = 0, last_p = 0, prev_p = 0, width_bad = 0;
  logic prev_rst = 0;

  indep_watchdog u0 (.bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .running(running),
    .osc_force_on(osc_force_on), .busy(busy), .count(count), .rst_req(rst_req));

  always #10 bus_clk = ~bus_clk;
  always #35 slow_clk = ~slow_clk;

  always @(negedge slow_clk) begin
    sc++;
    if (rst_req) begin
      pc++;
      prev_p = last_p;
      last_p = sc;
      if (prev_rst) width_bad++;
    end
    prev_rst = rst_req;
  end

  function automatic int exp_period(int pr, int rlr);
    return (4 << ((pr > 6) ? 6 : pr)) * (rlr + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 400 && busy != 0; t++) @(negedge bus_clk);
  endtask

  task automatic cfg(int pr, int rlr);
    wr(0, 16'h5555); wr(1, 16'(pr)); wait_idle();
    wr(2, 16'(rlr)); wait_idle();
    wr(0, 16'h0000);
  endtask

  task automatic wait_pulses(int n);
    int tgt;
    tgt = pc + n;
    for (int t = 0; t < 20000 && pc < tgt; t++) @(negedge slow_clk);
  endtask

  task automatic slow_wait(int n);
    repeat (n) @(negedge slow_clk);
  endtask

  task automatic measure(int pr, int rlr, string req);
    int p;
    wait_pulses(2);
    p = last_p - prev_p;
    chk(p == exp_period(pr, rlr), req, p, exp_period(pr, rlr));
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++; checks++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0, pr, rlr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge bus_clk);
    rst_n = 1;
    repeat (2) @(negedge bus_clk);
    // R1 reset state
    chk(running == 0 && osc_force_on == 0, "R1 run", running, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(count == 12'hFFF, "R1 count", count, 12'hFFF);
    chk(rst_req == 0, "R1 rst_req", rst_req, 0);

    // R5 locked write ignored
    wr(2, 16'd10);
    chk(busy == 0, "R5 locked busy", busy, 0);

    // R7 accepted write sets busy, write while busy ignored
    wr(0, 16'h5555);
    wr(1, 16'd1);
    chk(busy == 3'b001, "R7 busy set", busy, 1);
    wr(1, 16'd3);
    wait_idle();
    chk(busy == 0, "R7 busy clear", busy, 0);
    wr(2, 16'd9); wait_idle();

    // R6 other keys relock
    wr(0, 16'h1234); wr(2, 16'd50);
    chk(busy == 0, "R6 relock other", busy, 0);
    wr(0, 16'h5555); wr(0, 16'hAAAA); wr(1, 16'd5);
    chk(busy == 0, "R6 relock feed key", busy, 0);

    // R2 start
    wr(0, 16'hCCCC);
    chk(running == 1 && osc_force_on == 1, "R2 start", running, 1);
    wr(0, 16'h5555); wr(0, 16'hCCCC); wr(2, 16'd40);
    chk(busy == 0, "R6 relock start key", busy, 0);
    // R3 R5 R7: period uses PR=1 RLR=9
    measure(1, 9, "R3 R5 R7 period");

    // R3 random configurations
    for (int i = 0; i < 6; i++) begin
      pr = $urandom_range(0, 7);
      rlr = $urandom_range(0, 15);
      cfg(pr, rlr);
      measure(pr, rlr, "R3 random period");
    end
    cfg(7, 1);
    measure(7, 1, "R3 capped divider");
    cfg(0, 0);
    measure(0, 0, "R3 zero reload");

    // R10 no key stops the timer
    wr(0, 16'h0000); wr(0, 16'hFFFF); wr(0, 16'hCCCC);
    wr(0, 16'($urandom()));
    chk(running == 1, "R10 still running", running, 1);
    p0 = pc;
    wait_pulses(2);
    chk(pc >= p0 + 2, "R10 expiries continue", pc, p0 + 2);

    // R9 window
    cfg(2, 200);
    wr(0, 16'h5555); wr(3, 16'd20); wait_idle();
    wait_pulses(1);
    slow_wait(5);
    p0 = pc;
    wr(0, 16'hAAAA);
    slow_wait(30);
    chk(pc == p0 + 1, "R9 early refresh reset", pc, p0 + 1);
    for (int t = 0; t < 5000 && count > 15; t++) @(negedge slow_clk);
    p0 = pc;
    wr(0, 16'hAAAA);
    slow_wait(30);
    chk(pc == p0, "R9 late refresh allowed", pc, p0);
    chk(count >= 195, "R8 refresh reload", count, 200);
    wr(0, 16'h5555); wr(3, 16'hFFF); wait_idle();
    wait_pulses(1);
    slow_wait(5);
    p0 = pc;
    wr(0, 16'hAAAA);
    slow_wait(30);
    chk(pc == p0, "R9 window disabled", pc, p0);

    // R8 regular refresh prevents expiry
    p0 = pc;
    for (int i = 0; i < 12; i++) begin
      slow_wait(1500);
      wr(0, 16'hAAAA);
    end
    chk(pc == p0, "R8 no expiry with refresh", pc, p0);

    // R4 pulse width
    chk(width_bad == 0, "R4 pulse width", width_bad, 0);

    // R10 only reset clears
    @(negedge bus_clk); rst_n = 0;
    @(negedge bus_clk); rst_n = 1;
    @(negedge bus_clk);
    chk(running == 0 && count == 12'hFFF, "R10 reset clears", running, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule